// File: doc/BRIEF.md
# Two-Channel Fixed-Period Peak-Current Chopper

This block chops the drive of two motor windings against a peak-current limit. A shared free-running counter splits time into periods of 2^PERIOD_W system clocks (256 by default). At the first clock of every period both channels switch their winding drive on together. Each channel has a digital trip input from an external current comparator. The block resynchronizes that input, masks it for a programmable blanking window at the start of the period, and then latches the channel off once the trip is seen. The channel stays off until the next period begins. The comparators and the reference converters sit outside the block.

A per-channel decay select picks which outputs carry the chopping. With fast decay, the active-low inhibit line of the channel is chopped and the two phase lines hold the requested polarity. With slow decay, the inhibit line stays high and the phase lines are chopped. An active-low sync pulse marks the start of every period. A global disable forces every drive output low.

The position is the counter value, from 0 to 2^PERIOD_W-1. Position 0 is the first clock of a period. The counter is held at 0 during reset and counts up from the first clock after reset is released. Channel drive is "on" when it is not chopped off in the current period.

Top module: `chop_core`

## Requirements
- R1: The period is exactly 2^PERIOD_W clocks. `sync_no` is 0 during positions 0 to SYNC_LEN-1 of every period and 1 at all other positions. It is also 0 while reset is held, because the position is held at 0.
- R2: At the start of every period, both channels turn their drive on on the same clock, whatever happened in the previous period.
- R3: A trip input takes effect two clocks after it is applied, because it passes through a two-stage synchronizer. Once a trip is seen after blanking, that channel's drive stays off until the end of the period, even if the trip goes away. A trip on one channel has no effect on the other channel.
- R4: A synchronized trip is ignored while the position is below the effective blanking length. If the synchronized trip is already high when the position reaches that length, the drive turns off on that same clock.
- R5: A blanking length of 0 masks nothing. A blanking length of 2^PERIOD_W-1 or more is clamped to 2^PERIOD_W-1, so a held trip still turns the drive off on the last clock of the period.
- R6: A decay select bit of 0 means fast decay. In this mode `phase_o` of channel c (bits 2c+1:2c) equals `pol_in` bits 2c+1:2c, and `inh_no[c]` is 1 while the drive is on and 0 while it is off.
- R7: A decay select bit of 1 means slow decay. In this mode `inh_no[c]` is held at 1, and `phase_o` bits 2c+1:2c equal `pol_in` bits 2c+1:2c ANDed with the drive-on state.
- R8: While `drive_dis` is 1, every bit of `phase_o` and `inh_no` is 0. The period timing, the sync output and the latched chopping state go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_in | input | NUM_CH | Asynchronous overcurrent trips, one per channel |
| slow_sel | input | NUM_CH | Decay select per channel: 0 fast, 1 slow |
| pol_in | input | 2*NUM_CH | Requested phase polarity, two bits per channel |
| blank_len | input | BLANK_W | Blanking length in clocks |
| drive_dis | input | 1 | Forces all drive outputs low |
| phase_o | output | 2*NUM_CH | Phase drive outputs |
| inh_no | output | NUM_CH | Active-low inhibit outputs |
| sync_no | output | 1 | Active-low period-start pulse |

## Verification
The bench builds the block with PERIOD_W=6, SYNC_LEN=8 and BLANK_W=7. A 64-clock period lets the bench sweep trip positions across every part of the period, for blanking lengths from 0 up to 127, in a few thousand clocks. The 7-bit blanking field reaches values well past the clamp point of 63. This exposes both the zero-mask case and the clamp case. It also covers trips held across period boundaries, single-clock trip pulses inside and outside the blanking window, all sixteen polarity patterns in each decay mode, and disable in the middle of a period.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic {
        DECAY_FAST = 1'b0,
        DECAY_SLOW = 1'b1
    } decay_e;

    typedef struct packed {
        logic [1:0] phase;
        logic       inh_n;
    } chan_out_t;

    // Route one chopping decision to either the inhibit or the phase lines.
    function automatic chan_out_t steer(input decay_e md, input logic drv,
                                        input logic [1:0] pl, input logic dis);
        chan_out_t r;
        if (dis) begin
            r.phase = 2'b00;
            r.inh_n = 1'b0;
        end else if (md == DECAY_SLOW) begin
            r.phase = pl & {2{drv}};
            r.inh_n = 1'b1;
        end else begin
            r.phase = pl;
            r.inh_n = drv;
        end
        return r;
    endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
    parameter int PERIOD_W = 8,
    parameter int SYNC_LEN = 16
) (
    input  logic                clk,
    input  logic                rst,
    output logic [PERIOD_W-1:0] pos,
    output logic                period_last,
    output logic                sync_no
);
    localparam logic [PERIOD_W-1:0] LAST = {PERIOD_W{1'b1}};

    logic [PERIOD_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else if (pos_q == LAST) pos_q <= '0;
        else pos_q <= pos_q + 1'b1;
    end

    assign pos         = pos_q;
    assign period_last = (pos_q == LAST);
    assign sync_no     = !(int'(pos_q) < SYNC_LEN);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (pos_q == LAST) |=> (pos_q == '0));
    assert_sync_start_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_no) |-> (pos_q == '0));
endmodule

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/chop_channel.sv
module chop_channel
    import chop_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] pos,
    input  logic                period_last,
    input  logic [PERIOD_W-1:0] blank_eff,
    input  logic                trip_s,
    input  decay_e              mode,
    input  logic [1:0]          pol,
    input  logic                dis,
    output chan_out_t           out,
    output logic                drive
);
    logic off_q;
    logic past_blank;
    logic trip_hit;

    assign past_blank = (pos >= blank_eff);
    assign trip_hit   = trip_s && past_blank;
    assign drive      = !(off_q || trip_hit);

    always_ff @(posedge clk) begin
        if (rst) off_q <= 1'b0;
        else if (period_last) off_q <= 1'b0;
        else if (trip_hit) off_q <= 1'b1;
    end

    always_comb out = steer(mode, drive, pol, dis);

    assert_stay_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!drive && !period_last) |=> !drive);
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (period_last && !trip_s) |=> drive || trip_s);
    assert_blank_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (pos < blank_eff && pos != '0 && $past(drive)) |-> drive);
endmodule

// File: rtl/chop_core.sv
module chop_core
    import chop_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int PERIOD_W = 8,
    parameter int SYNC_LEN = 16,
    parameter int BLANK_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     trip_in,
    input  logic [NUM_CH-1:0]     slow_sel,
    input  logic [2*NUM_CH-1:0]   pol_in,
    input  logic [BLANK_W-1:0]    blank_len,
    input  logic                  drive_dis,
    output logic [2*NUM_CH-1:0]   phase_o,
    output logic [NUM_CH-1:0]     inh_no,
    output logic                  sync_no
);
    localparam int LAST = (1 << PERIOD_W) - 1;

    logic [PERIOD_W-1:0] pos;
    logic                period_last;
    logic [PERIOD_W-1:0] blank_eff;
    logic [NUM_CH-1:0]   trip_s;
    logic [NUM_CH-1:0]   drive;

    chop_timebase #(.PERIOD_W(PERIOD_W), .SYNC_LEN(SYNC_LEN)) u_tb (
        .clk(clk), .rst(rst), .pos(pos),
        .period_last(period_last), .sync_no(sync_no)
    );

    chop_sync #(.WIDTH(NUM_CH), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(trip_in), .q(trip_s)
    );

    // Clamp so a held trip can still end the drive on the last clock.
    always_comb begin
        if (int'(blank_len) >= LAST) blank_eff = PERIOD_W'(LAST);
        else blank_eff = PERIOD_W'(blank_len);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_out_t co;
        decay_e    md;
        assign md = slow_sel[c] ? DECAY_SLOW : DECAY_FAST;

        chop_channel #(.PERIOD_W(PERIOD_W)) u_ch (
            .clk(clk), .rst(rst), .pos(pos), .period_last(period_last),
            .blank_eff(blank_eff), .trip_s(trip_s[c]), .mode(md),
            .pol(pol_in[2*c+1:2*c]), .dis(drive_dis),
            .out(co), .drive(drive[c])
        );

        assign phase_o[2*c+1:2*c] = co.phase;
        assign inh_no[c]          = co.inh_n;

        assert_slow_inh_R7: assert property (@(posedge clk) disable iff (rst)
            (!drive_dis && slow_sel[c]) |-> inh_no[c]);
        assert_fast_phase_R6: assert property (@(posedge clk) disable iff (rst)
            (!drive_dis && !slow_sel[c]) |-> (phase_o[2*c+1:2*c] == pol_in[2*c+1:2*c]));
    end

    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
        drive_dis |-> (phase_o == '0 && inh_no == '0));
endmodule

// File: tb/chop_core_test.sv
module chop_core_test;
    localparam int PW   = 6;
    localparam int P    = 1 << PW;
    localparam int LAST = P - 1;
    localparam int SL   = 8;
    localparam int BW   = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    trip_in = '0;
    logic [1:0]    slow_sel = '0;
    logic [3:0]    pol_in = 4'b1001;
    logic [BW-1:0] blank_len = '0;
    logic          drive_dis = 1'b0;
    logic [3:0]    phase_o;
    logic [1:0]    inh_no;
    logic          sync_no;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    chop_core #(.NUM_CH(2), .PERIOD_W(PW), .SYNC_LEN(SL), .BLANK_W(BW)) uut (
        .clk(clk), .rst(rst), .trip_in(trip_in), .slow_sel(slow_sel),
        .pol_in(pol_in), .blank_len(blank_len), .drive_dis(drive_dis),
        .phase_o(phase_o), .inh_no(inh_no), .sync_no(sync_no)
    );

    always #2 clk = ~clk;

    // Requirement model: position, two-clock trip latency, per-period latch.
    int   mpos = 0;
    logic [1:0] t1 = '0, t2 = '0, moff = '0;

    function automatic int beff();
        return (int'(blank_len) >= LAST) ? LAST : int'(blank_len);
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            mpos <= 0; t1 <= '0; t2 <= '0; moff <= '0;
        end else begin
            mpos <= (mpos == LAST) ? 0 : mpos + 1;
            t1 <= trip_in;
            t2 <= t1;
            for (int c = 0; c < 2; c++) begin
                if (mpos == LAST) moff[c] <= 1'b0;
                else if (t2[c] && mpos >= beff()) moff[c] <= 1'b1;
            end
        end
    end

    task automatic fail_line(string req, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s at pos %0d: actual=%0h expected=%0h", req, what, mpos, act, exp);
    endtask

    always @(negedge clk) begin
        logic [3:0] eph;
        logic [1:0] einh;
        checks++;
        if (sync_no !== ((mpos < SL) ? 1'b0 : 1'b1))
            fail_line(rst ? "R1 (reset)" : "R1", "sync_no", int'(sync_no), (mpos < SL) ? 0 : 1);
        for (int c = 0; c < 2; c++) begin
            logic d;
            d = !(moff[c] || (t2[c] && mpos >= beff()));
            if (drive_dis) begin
                eph[2*c+:2] = 2'b00; einh[c] = 1'b0;
            end else if (slow_sel[c]) begin
                eph[2*c+:2] = pol_in[2*c+:2] & {2{d}}; einh[c] = 1'b1;
            end else begin
                eph[2*c+:2] = pol_in[2*c+:2]; einh[c] = d;
            end
        end
        checks++;
        if (phase_o !== eph) fail_line(tag, "phase_o", int'(phase_o), int'(eph));
        checks++;
        if (inh_no !== einh) fail_line(tag, "inh_no", int'(inh_no), int'(einh));
    end

    // mode: 0 level from tp on, 1 single-clock pulse at tp, 2 held all period, 3 none
    task automatic run_period(string req, int bl, logic [1:0] slow, logic [3:0] pl,
                              logic dis, int tp0, int tp1, int m0, int m1);
        while (mpos != 0) begin @(posedge clk); #1; end
        tag = req; blank_len = BW'(bl); slow_sel = slow; pol_in = pl; drive_dis = dis;
        repeat (P) begin
            trip_in[0] = (m0 == 2) || (m0 == 0 && mpos >= tp0) || (m0 == 1 && mpos == tp0);
            trip_in[1] = (m1 == 2) || (m1 == 0 && mpos >= tp1) || (m1 == 1 && mpos == tp1);
            @(posedge clk); #1;
        end
        trip_in = '0;
    endtask

    initial begin
        int blanks [9] = '{0, 1, 3, 8, 30, 62, 63, 64, 127};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R3: level trips swept over the period, channels at different positions
        foreach (blanks[i])
            for (int tp = 0; tp <= LAST; tp += 7)
                run_period("R3", blanks[i], 2'(i % 4), 4'b0110, 1'b0, tp, LAST - tp, 0, 0);
        // R3: single-clock pulse after blanking still holds drive off; other channel idle
        run_period("R3", 4, 2'b00, 4'b1010, 1'b0, 20, 0, 1, 3);
        run_period("R3", 4, 2'b11, 4'b1010, 1'b0, 0, 33, 3, 1);
        // R4: pulse fully inside blanking ignored; held trip ends drive exactly at blank
        run_period("R4", 40, 2'b00, 4'b0101, 1'b0, 10, 30, 1, 1);
        run_period("R4", 17, 2'b01, 4'b0101, 1'b0, 0, 0, 2, 2);
        run_period("R4", 17, 2'b01, 4'b0101, 1'b0, 0, 0, 2, 2);
        // R2: held trips on both channels; both restart on the same clock each period
        run_period("R2", 10, 2'b00, 4'b1001, 1'b0, 0, 0, 2, 2);
        run_period("R2", 10, 2'b10, 4'b1001, 1'b0, 0, 0, 2, 2);
        // R5: zero blanking and clamped blanking with held trips
        run_period("R5", 0, 2'b00, 4'b1111, 1'b0, 0, 0, 2, 2);
        run_period("R5", 0, 2'b11, 4'b1111, 1'b0, 0, 0, 2, 2);
        run_period("R5", 127, 2'b00, 4'b1111, 1'b0, 0, 0, 2, 2);
        run_period("R5", 63, 2'b11, 4'b1111, 1'b0, 0, 0, 2, 2);
        // R6 / R7: every polarity pattern in each decay mode
        for (int p = 0; p < 16; p++)
            run_period("R6", 5, 2'b00, 4'(p), 1'b0, 12 + p, 40, 0, 0);
        for (int p = 0; p < 16; p++)
            run_period("R7", 5, 2'b11, 4'(p), 1'b0, 12 + p, 40, 0, 0);
        // R8: disable, then release mid-state so the latched chop shows through
        run_period("R8", 6, 2'b01, 4'b1111, 1'b1, 20, 9, 0, 1);
        run_period("R8", 6, 2'b10, 4'b1111, 1'b1, 0, 0, 3, 3);
        while (mpos != 30) begin @(posedge clk); #1; end
        tag = "R8"; drive_dis = 1'b1; trip_in = 2'b01;
        repeat (10) begin @(posedge clk); #1; end
        trip_in = '0; drive_dis = 1'b0;
        repeat (P) begin @(posedge clk); #1; end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog expired: actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule